// File: doc/BRIEF.md
# Attention Flag and Idle Notifier

This block gathers a set of attention request lines into sticky flags and tells a remote host about them. Each line that pulses high sets its own flag, and the flag stays set until the command engine reads the flags with a read-and-clear strobe. A single pending output, the OR of all flags, feeds the status byte that the command engine builds. Because the clear happens first, a status byte built right after an attention read already shows no pending attention.

Toward the host, the block offers 9-bit out-of-band comma symbols to a downstream serializer. Top bit set and low byte 0x00 is the idle comma. Top bit set and low byte 0x04 is the attention comma. A symbol is sent in three cases:
- when notification is enabled and a new attention event arrives;
- when the keep-alive timer expires;
- in answer to each poll the host sends.

An answer to a poll or a timer expiry carries the attention comma while flags are pending, and the idle comma otherwise. The symbol state machine has three states:
- `ST_IDLE`: nothing is offered.
- `ST_DEFER`: a request is waiting because a response packet is in progress.
- `ST_EMIT`: a symbol is offered.

The transitions are:
- IDLE to EMIT when a request exists and no response is active.
- IDLE to DEFER when a request exists during a response.
- DEFER to EMIT when the response ends.
- EMIT to IDLE when the serializer accepts the symbol.

Top module: `attn_notifier`

## Requirements
- R1: After reset, `flags_o` is 0, `pending_o` is 0 and `sym_valid` is 0. Notification and keep-alive are both disabled.
- R2: A 1 on bit i of `attn_in` in a cycle sets flag i from the next cycle on. The flag stays set until cleared. `pending_o` is 1 exactly when some flag is set.
- R3: In a cycle with `rdclr` high, `flags_o` shows the flags being read. In the next cycle the flags equal only the `attn_in` bits that were high during the `rdclr` cycle, so an event that coincides with the clear is kept. If there was no such event, `pending_o` is 0.
- R4: A `cfg_we` pulse loads the settings from `cfg_data`. Bit 15 is the notification enable. Bit 14 is the keep-alive enable. Bits 13:0 hold the timeout value n.
- R5: Every offered symbol is either 9'h100 (idle comma) or 9'h104 (attention comma).
- R6: With notification enabled, an event on a line whose flag is clear causes one attention comma. An event on a line whose flag is already set causes none.
- R7: With keep-alive enabled, no other traffic and `sym_ready` held high, keep-alive symbols are offered every 20*(n+1) cycles. Each is the attention comma if flags are pending and the idle comma otherwise.
- R8: Each `poll_in` pulse gets exactly one answer symbol. The answer is the attention comma if flags are pending when it is loaded, otherwise the idle comma. Up to 15 polls may be outstanding.
- R9: No symbol starts while `resp_active` is high. A symbol that was held back starts in the first cycle after `resp_active` falls. `resp_active` restarts the keep-alive timer.
- R10: While `sym_valid` is high and `sym_ready` is low, `sym_valid` stays high and `sym_data` does not change.
- R11: With keep-alive and notification disabled and no polls, no symbol is ever offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| attn_in | input | 16 | Attention request lines, one cycle per event |
| rdclr | input | 1 | Read-and-clear strobe from the command engine |
| flags_o | output | 16 | Current sticky flags |
| pending_o | output | 1 | OR of all flags |
| cfg_we | input | 1 | Settings write strobe |
| cfg_data | input | 16 | Settings word |
| poll_in | input | 1 | Host poll comma received |
| resp_active | input | 1 | Response packet in progress toward the host |
| sym_valid | output | 1 | Out-of-band symbol offered |
| sym_ready | input | 1 | Serializer accepts the offered symbol |
| sym_data | output | 9 | Offered symbol |

## Verification
The hardest situation to reach from the ports is a symbol deferred behind a response while the keep-alive timer is also running. The exact cycle of the release and of the following tick both depend on when the timer was last restarted. The stimulus holds `resp_active` high across a poll, drops it, and then checks two things against cycle stamps the bench keeps itself: the poll answer appears one cycle later, and the next keep-alive appears exactly 20*(n+1) cycles after that answer. Random sparse event patterns with random clears exercise the coincidence of an event and a clear. Separate directed runs compare the spacing of keep-alive symbols for two timeout values.

// File: rtl/attn_pkg.sv
package attn_pkg;
    localparam logic [8:0] SYM_IDLE = 9'h100;
    localparam logic [8:0] SYM_ATTN = 9'h104;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DEFER = 2'd1,
        ST_EMIT  = 2'd2
    } nst_t;
endpackage

// File: rtl/attn_flags.sv
module attn_flags #(
    parameter int NLINES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] attn_in,
    input  logic              rdclr,
    output logic [NLINES-1:0] flags,
    output logic              new_evt
);
    logic [NLINES-1:0] flags_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (rdclr ? '0 : flags_q) | attn_in;
    end

    assign flags   = flags_q;
    assign new_evt = |(attn_in & ~flags_q);
endmodule

// File: rtl/idle_timer.sv
module idle_timer #(
    parameter int PRE_DIV = 20,
    parameter int N_W     = 14
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enable,
    input  logic           restart,
    input  logic [N_W-1:0] n,
    output logic           expire
);
    localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

    logic [PRE_W-1:0] pre_q;
    logic [N_W-1:0]   div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            div_q <= '0;
        end else if (!enable || restart) begin
            pre_q <= '0;
            div_q <= '0;
        end else if (pre_q == PRE_LAST) begin
            pre_q <= '0;
            div_q <= (div_q == n) ? '0 : div_q + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign expire = enable && (pre_q == PRE_LAST) && (div_q == n);
endmodule

// File: rtl/notify_fsm.sv
module notify_fsm
    import attn_pkg::*;
#(
    parameter int POLL_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pending,
    input  logic       note_evt,
    input  logic       poll_in,
    input  logic       expire,
    input  logic       resp_active,
    input  logic       sym_ready,
    output logic       sym_valid,
    output logic [8:0] sym_data,
    output logic       load
);
    localparam logic [POLL_W-1:0] POLL_MAX = '1;

    nst_t              state_q, state_d;
    logic [POLL_W-1:0] poll_cnt;
    logic              note_pend, tick_pend;
    logic [8:0]        sym_q;
    logic              have_req, take_poll, take_note, take_tick, poll_inc;

    // next state and request selection
    always_comb begin
        have_req = (poll_cnt != '0) || note_pend || tick_pend || expire;
        load     = 1'b0;
        state_d  = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (have_req) begin
                    if (resp_active) begin
                        state_d = ST_DEFER;
                    end else begin
                        state_d = ST_EMIT;
                        load    = 1'b1;
                    end
                end
            end
            ST_DEFER: begin
                if (!resp_active) begin
                    state_d = ST_EMIT;
                    load    = 1'b1;
                end
            end
            ST_EMIT: begin
                if (sym_ready) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
        take_poll = load && (poll_cnt != '0);
        take_note = load && !take_poll && note_pend;
        take_tick = load && !take_poll && !note_pend;
        poll_inc  = poll_in && ((poll_cnt != POLL_MAX) || take_poll);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request bookkeeping and symbol register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            poll_cnt  <= '0;
            note_pend <= 1'b0;
            tick_pend <= 1'b0;
            sym_q     <= SYM_IDLE;
        end else begin
            poll_cnt  <= poll_cnt + POLL_W'(poll_inc) - POLL_W'(take_poll);
            note_pend <= (note_pend && !take_note) || note_evt;
            tick_pend <= (tick_pend || expire) && !take_tick;
            if (load) sym_q <= (take_note || pending) ? SYM_ATTN : SYM_IDLE;
        end
    end

    // outputs
    always_comb begin
        sym_valid = (state_q == ST_EMIT);
        sym_data  = sym_q;
    end
endmodule

// File: rtl/attn_notifier.sv
module attn_notifier #(
    parameter int NLINES  = 16,
    parameter int CFG_W   = 16,
    parameter int PRE_DIV = 20,
    parameter int POLL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] attn_in,
    input  logic              rdclr,
    output logic [NLINES-1:0] flags_o,
    output logic              pending_o,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_data,
    input  logic              poll_in,
    input  logic              resp_active,
    output logic              sym_valid,
    input  logic              sym_ready,
    output logic [8:0]        sym_data
);
    localparam int N_W = CFG_W - 2;

    logic           an_en, ito_en;
    logic [N_W-1:0] ito_n;
    logic           new_evt, expire, load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            an_en  <= 1'b0;
            ito_en <= 1'b0;
            ito_n  <= '0;
        end else if (cfg_we) begin
            an_en  <= cfg_data[CFG_W-1];
            ito_en <= cfg_data[CFG_W-2];
            ito_n  <= cfg_data[N_W-1:0];
        end
    end

    attn_flags #(.NLINES(NLINES)) i_flags (
        .clk(clk), .rst_n(rst_n), .attn_in(attn_in), .rdclr(rdclr),
        .flags(flags_o), .new_evt(new_evt)
    );

    assign pending_o = |flags_o;

    idle_timer #(.PRE_DIV(PRE_DIV), .N_W(N_W)) i_timer (
        .clk(clk), .rst_n(rst_n), .enable(ito_en),
        .restart(load || resp_active || cfg_we), .n(ito_n), .expire(expire)
    );

    notify_fsm #(.POLL_W(POLL_W)) i_fsm (
        .clk(clk), .rst_n(rst_n), .pending(pending_o),
        .note_evt(new_evt && an_en), .poll_in(poll_in), .expire(expire),
        .resp_active(resp_active), .sym_ready(sym_ready),
        .sym_valid(sym_valid), .sym_data(sym_data), .load(load)
    );
endmodule

// File: rtl/attn_notifier_chk.sv
module attn_notifier_chk
    import attn_pkg::*;
#(
    parameter int NLINES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NLINES-1:0] attn_in,
    input logic              rdclr,
    input logic [NLINES-1:0] flags_o,
    input logic              pending_o,
    input logic              resp_active,
    input logic              sym_valid,
    input logic              sym_ready,
    input logic [8:0]        sym_data
);
    logic seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        seen && !$past(rdclr) |-> ((flags_o & $past(flags_o)) == $past(flags_o))); // R2
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> ((flags_o & $past(attn_in)) == $past(attn_in))); // R2
    AST_CLEAR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        seen && $past(rdclr) |-> (flags_o == $past(attn_in))); // R3
    AST_PEND_AFTER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        seen && $past(rdclr) && ($past(attn_in) == '0) |-> !pending_o); // R3
    AST_SYM_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |-> (sym_data == SYM_IDLE || sym_data == SYM_ATTN)); // R5
    AST_NO_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        seen && sym_valid && !$past(sym_valid) |-> !$past(resp_active)); // R9
    AST_SYM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        seen && $past(sym_valid && !sym_ready) |-> sym_valid && $stable(sym_data)); // R10
endmodule

bind attn_notifier attn_notifier_chk #(.NLINES(NLINES)) i_chk (
    .clk(clk), .rst_n(rst_n), .attn_in(attn_in), .rdclr(rdclr),
    .flags_o(flags_o), .pending_o(pending_o), .resp_active(resp_active),
    .sym_valid(sym_valid), .sym_ready(sym_ready), .sym_data(sym_data)
);

// File: tb/test_attn_notifier.sv
module test_attn_notifier;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] attn_in = '0;
    logic        rdclr = 1'b0;
    logic [15:0] flags_o;
    logic        pending_o;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_data = '0;
    logic        poll_in = 1'b0;
    logic        resp_active = 1'b0;
    logic        sym_valid;
    logic        sym_ready = 1'b1;
    logic [8:0]  sym_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int sym_n = 0;
    logic [8:0] sym_log [0:255];
    int         sym_cyc [0:255];

    attn_notifier i_attn_notifier (.*);

    always #10 clk = ~clk;   // 50 MHz

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && sym_valid && sym_ready && sym_n < 256) begin
            sym_log[sym_n] = sym_data;
            sym_cyc[sym_n] = cyc;
            sym_n = sym_n + 1;
        end
    end

    function automatic logic [8:0] exp_sym(input bit pend);
        return pend ? 9'h104 : 9'h100;
    endfunction

    function automatic logic [15:0] cfg_word(input bit an, input bit ito, input int n);
        return {an, ito, 14'(n)};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_cfg(input logic [15:0] w);
        cfg_data = w; cfg_we = 1'b1;
        step(1);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_attn(input logic [15:0] m);
        attn_in = m;
        step(1);
        attn_in = '0;
    endtask

    task automatic clear_flags;
        rdclr = 1'b1;
        step(1);
        rdclr = 1'b0;
    endtask

    task automatic pulse_poll(input int k);
        for (int i = 0; i < k; i++) begin
            poll_in = 1'b1;
            step(1);
        end
        poll_in = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] exp_f;
        logic [8:0]  held;
        int n0, cd;
        void'($urandom(32'd1234));

        step(3);
        @(negedge clk);
        chk(flags_o == 0 && pending_o == 0 && sym_valid == 0, "R1 reset state",
            {flags_o, pending_o, sym_valid}, 0);
        rst_n = 1'b1;
        step(1);

        // R2/R3: random sparse events with random clears
        exp_f = '0;
        for (int i = 0; i < 300; i++) begin
            logic [15:0] a;
            logic        r;
            a = 16'($urandom & $urandom & $urandom);
            if ($urandom % 3 == 0) a = '0;
            r = ($urandom % 8 == 0);
            attn_in = a; rdclr = r;
            @(negedge clk);
            chk(flags_o == exp_f, r ? "R3 read value" : "R2 sticky flags", flags_o, exp_f);
            chk(pending_o == (exp_f != 0), "R2 pending", pending_o, exp_f != 0);
            exp_f = (r ? 16'h0 : exp_f) | a;
            step(1);
        end
        attn_in = '0; rdclr = 1'b0;
        step(1);
        chk(sym_n == 0, "R11 no symbols while disabled", sym_n, 0);

        // R3: event coinciding with the clear is kept
        pulse_attn(16'h00F0);
        attn_in = 16'h0020; rdclr = 1'b1;
        step(1);
        attn_in = '0; rdclr = 1'b0;
        @(negedge clk);
        chk(flags_o == 16'h0020, "R3 coincident event kept", flags_o, 16'h0020);
        clear_flags();
        @(negedge clk);
        chk(pending_o == 0, "R3 pending clear after read", pending_o, 0);

        // R8: polls answered idle, then attention
        n0 = sym_n;
        pulse_poll(3);
        step(10);
        chk(sym_n == n0 + 3, "R8 three answers", sym_n - n0, 3);
        for (int i = 0; i < 3; i++)
            chk(sym_log[n0+i] == exp_sym(0), "R8 idle answer", sym_log[n0+i], exp_sym(0));
        pulse_attn(16'h0400);
        n0 = sym_n;
        pulse_poll(2);
        step(10);
        chk(sym_n == n0 + 2, "R8 two answers", sym_n - n0, 2);
        chk(sym_log[n0] == exp_sym(1) && sym_log[n0+1] == exp_sym(1), "R8 attn answer",
            sym_log[n0], exp_sym(1));
        clear_flags();

        // R6/R4: notification enable (bit 15)
        set_cfg(cfg_word(1, 0, 0));
        n0 = sym_n;
        pulse_attn(16'h0001);
        step(20);
        chk(sym_n == n0 + 1, "R6 one notification", sym_n - n0, 1);
        chk(sym_log[n0] == exp_sym(1), "R6 attention comma", sym_log[n0], exp_sym(1));
        n0 = sym_n;
        pulse_attn(16'h0001);
        step(20);
        chk(sym_n == n0, "R6 no notify for set flag", sym_n - n0, 0);
        clear_flags();
        set_cfg(cfg_word(0, 0, 0));

        // R10: hold while not ready
        sym_ready = 1'b0;
        pulse_poll(1);
        step(3);
        @(negedge clk);
        held = sym_data;
        chk(sym_valid == 1, "R10 offered", sym_valid, 1);
        step(5);
        @(negedge clk);
        chk(sym_valid == 1 && sym_data == held, "R10 held stable", sym_data, held);
        n0 = sym_n;
        sym_ready = 1'b1;
        step(5);
        chk(sym_n == n0 + 1, "R10 accepted once", sym_n - n0, 1);

        // R7/R4: keep-alive spacing n=2 and n=0
        set_cfg(cfg_word(0, 1, 2));
        step(250);
        chk(sym_cyc[sym_n-1] - sym_cyc[sym_n-2] == 60, "R7 spacing n=2",
            sym_cyc[sym_n-1] - sym_cyc[sym_n-2], 60);
        chk(sym_log[sym_n-1] == exp_sym(0), "R7 idle keep-alive", sym_log[sym_n-1], exp_sym(0));
        set_cfg(cfg_word(0, 1, 0));
        step(70);
        chk(sym_cyc[sym_n-1] - sym_cyc[sym_n-2] == 20, "R7 spacing n=0",
            sym_cyc[sym_n-1] - sym_cyc[sym_n-2], 20);
        pulse_attn(16'h0008);
        step(50);
        chk(sym_log[sym_n-1] == exp_sym(1), "R7 attn keep-alive", sym_log[sym_n-1], exp_sym(1));
        clear_flags();

        // R9: deferred behind a response
        resp_active = 1'b1;
        step(2);
        n0 = sym_n;
        pulse_poll(1);
        step(100);
        chk(sym_n == n0, "R9 nothing during response", sym_n - n0, 0);
        resp_active = 1'b0;
        cd = cyc;
        step(30);
        chk(sym_n >= n0 + 2, "R9 release count", sym_n - n0, 2);
        chk(sym_cyc[n0] == cd + 1, "R9 release cycle", sym_cyc[n0], cd + 1);
        chk(sym_log[n0] == exp_sym(0), "R9 poll answer idle", sym_log[n0], exp_sym(0));
        chk(sym_cyc[n0+1] == cd + 21, "R9 timer restarted", sym_cyc[n0+1], cd + 21);

        // R11: everything off
        set_cfg(cfg_word(0, 0, 0));
        step(5);
        n0 = sym_n;
        step(300);
        chk(sym_n == n0, "R11 quiet when disabled", sym_n - n0, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule